// File: doc/BRIEF.md
# CRC32C Checksum-Accumulate Execution Unit

This block executes one checksum-accumulate instruction per cycle using the Castagnoli CRC polynomial. With each valid beat it takes a 32-bit instruction word, a 32-bit running checksum and a 64-bit data operand. It decodes the word, folds 8, 16, 32 or 64 data bits into the checksum, and returns the new checksum one cycle later. If the word is not a legal form of this instruction, or if the CRC feature is switched off, it raises an undefined-instruction flag.

The arithmetic follows the reflected convention, which is equivalent to reversing the accumulator, the data and the remainder around an unreflected division by 0x1EDC6F41. In reflected form the constant is 0x82F63B78. Software applies any initial or final inversion. The destination register index comes out together with the result so that a write-back stage can use it.

Top module: `crc32c_exec_unit`

## Requirements
- R1: `res_valid` is high exactly in the cycle after each cycle in which `op_valid` was high, whatever the width or the operand values, and it is low after reset.
- R2: Byte form (bit 31 = 0, bits [11:10] = 00): `res_crc` is the reflected CRC of `src_data[7:0]` folded into `src_acc`, with no inversion. Per bit i from 0 upward: fb = crc[0] ^ d[i]; crc >>= 1; if fb then crc ^= 0x82F63B78.
- R3: Halfword form (bit 31 = 0, bits [11:10] = 01) applies the same update over `src_data[15:0]`.
- R4: Word form (bit 31 = 0, bits [11:10] = 10) applies the same update over `src_data[31:0]`.
- R5: Doubleword form (bit 31 = 1, bits [11:10] = 11) applies the same update over all 64 bits of `src_data`.
- R6: Data bits above the selected width have no effect on `res_crc`.
- R7: The combinations bit 31 = 1 with size not 11, and bit 31 = 0 with size 11, set `res_undef` and force `res_crc` to zero.
- R8: A word whose fixed bits differ from bit 30 = 0, bit 29 = 0, bits [28:21] = 11010110, bits [15:13] = 010 and bit 12 = 1 sets `res_undef`.
- R9: While `crc_enable` is low, every word sets `res_undef`.
- R10: `res_dst` carries bits [4:0] of the instruction word, registered alongside the result.
- R11: Chained byte operations on "123456789", starting from 0xFFFFFFFF and inverted at the end, give 0xE3069283. One word operation equals four chained byte operations on the same bytes taken in little-endian order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Instruction beat present |
| op_word | input | 32 | Instruction word |
| src_acc | input | 32 | Incoming checksum |
| src_data | input | 64 | Data operand |
| crc_enable | input | 1 | CRC feature implemented |
| res_valid | output | 1 | Result beat present |
| res_crc | output | 32 | Updated checksum, zero when undefined |
| res_undef | output | 1 | Undefined-instruction flag |
| res_dst | output | 5 | Destination register index |

## Verification
Every result, including the undefined flag and the destination index, is due on the first rising edge after the beat is presented, whatever the width or the data. The bench drives each beat on a falling edge and samples all outputs on the following falling edge, which falls half a cycle after that register update. It then drops `op_valid` and checks one cycle later that `res_valid` has gone low again. Chained operations feed back each sampled result as the next accumulator, so the checks follow the same one-cycle rhythm.

// File: rtl/crc32c_pkg.sv
package crc32c_pkg;

    localparam int          WORD_W   = 32;
    localparam int          DATA_W   = 64;
    localparam int          REG_IDX_W = 5;
    localparam int          NUM_SIZES = 4;
    localparam logic [31:0] POLY_NORMAL = 32'h1EDC6F41;

    function automatic logic [31:0] reverse32(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = v[31-i];
        return r;
    endfunction

    localparam logic [31:0] POLY_REFL = reverse32(POLY_NORMAL);

    // fixed opcode fields
    localparam logic [7:0] OPC_MID = 8'b1101_0110;
    localparam logic [2:0] OPC_LOW = 3'b010;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_DBL  = 2'b11
    } crc_size_e;

    typedef struct packed {
        logic                 legal;
        crc_size_e            size;
        logic [REG_IDX_W-1:0] dst;
    } crc_dec_t;

endpackage

// File: rtl/crc32c_decode.sv
module crc32c_decode
    import crc32c_pkg::*;
(
    input  logic [31:0] word,
    input  logic        enable,
    output crc_dec_t    dec
);
    logic wide_flag;
    logic opcode_ok;
    logic width_ok;

    always_comb begin
        wide_flag = word[31];
        opcode_ok = (word[30:29] == 2'b00) && (word[28:21] == OPC_MID) &&
                    (word[15:13] == OPC_LOW) && word[12];
        width_ok  = wide_flag ? (word[11:10] == 2'b11) : (word[11:10] != 2'b11);
        dec.legal = enable && opcode_ok && width_ok;
        dec.size  = crc_size_e'(word[11:10]);
        dec.dst   = word[REG_IDX_W-1:0];
    end
endmodule

// File: rtl/crc32c_fold.sv
module crc32c_fold
    import crc32c_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [WORD_W-1:0] acc,
    input  logic [W-1:0]      data,
    output logic [WORD_W-1:0] crc
);
    logic [WORD_W-1:0] c;
    logic              fb;

    always_comb begin
        c  = acc;
        fb = 1'b0;
        for (int i = 0; i < W; i++) begin
            fb = c[0] ^ data[i];
            c  = {1'b0, c[WORD_W-1:1]};
            if (fb) c = c ^ POLY_REFL;
        end
        crc = c;
    end
endmodule

// File: rtl/crc32c_exec_unit.sv
module crc32c_exec_unit
    import crc32c_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        op_valid,
    input  logic [31:0] op_word,
    input  logic [31:0] src_acc,
    input  logic [63:0] src_data,
    input  logic        crc_enable,
    output logic        res_valid,
    output logic [31:0] res_crc,
    output logic        res_undef,
    output logic [4:0]  res_dst
);
    crc_dec_t          dec;
    logic [WORD_W-1:0] per_width [NUM_SIZES];
    logic [WORD_W-1:0] picked;

    crc32c_decode u_dec (
        .word   (op_word),
        .enable (crc_enable),
        .dec    (dec)
    );

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_width
        localparam int FW = 8 << g;
        crc32c_fold #(.W(FW)) u_fold (
            .acc  (src_acc),
            .data (src_data[FW-1:0]),
            .crc  (per_width[g])
        );
    end

    always_comb picked = per_width[dec.size];

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_crc   <= '0;
            res_undef <= 1'b0;
            res_dst   <= '0;
        end else begin
            res_valid <= op_valid;
            if (op_valid) begin
                res_crc   <= dec.legal ? picked : '0;
                res_undef <= ~dec.legal;
                res_dst   <= dec.dst;
            end
        end
    end
endmodule

// File: rtl/crc32c_exec_unit_chk.sv
module crc32c_exec_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        op_valid,
    input logic [31:0] op_word,
    input logic        crc_enable,
    input logic        res_valid,
    input logic [31:0] res_crc,
    input logic        res_undef,
    input logic [4:0]  res_dst
);
    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> res_valid);
    // R1
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> !res_valid);
    // R7
    wide_bad_size_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_word[31] && op_word[11:10] != 2'b11) |=> res_undef);
    // R7
    narrow_bad_size_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !op_word[31] && op_word[11:10] == 2'b11) |=> res_undef);
    // R7
    undef_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_undef) |-> (res_crc == 32'h0));
    // R8
    variant_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !op_word[12]) |=> res_undef);
    // R9
    feature_off_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !crc_enable) |=> res_undef);
    // R10
    dst_pass_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> (res_dst == $past(op_word[4:0])));
endmodule

bind crc32c_exec_unit crc32c_exec_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .op_valid   (op_valid),
    .op_word    (op_word),
    .crc_enable (crc_enable),
    .res_valid  (res_valid),
    .res_crc    (res_crc),
    .res_undef  (res_undef),
    .res_dst    (res_dst)
);

// File: tb/crc32c_exec_unit_tb.sv
module crc32c_exec_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [31:0] op_word = '0;
    logic [31:0] src_acc = '0;
    logic [63:0] src_data = '0;
    logic        crc_enable = 1'b1;
    logic        res_valid;
    logic [31:0] res_crc;
    logic        res_undef;
    logic [4:0]  res_dst;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [63:0] lfsr = 64'hC0FFEE12_3456789B;

    always #10 clk = ~clk;

    crc32c_exec_unit u_dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_word(op_word),
        .src_acc(src_acc), .src_data(src_data), .crc_enable(crc_enable),
        .res_valid(res_valid), .res_crc(res_crc), .res_undef(res_undef),
        .res_dst(res_dst)
    );

    function automatic logic [31:0] ref_crc(input logic [31:0] acc,
                                            input logic [63:0] d, input int w);
        logic [31:0] c = acc;
        for (int i = 0; i < w; i++) begin
            logic fb = c[0] ^ d[i];
            c = c >> 1;
            if (fb) c = c ^ 32'h82F63B78;
        end
        return c;
    endfunction

    function automatic logic [31:0] mk(input logic sf, input logic [1:0] sz,
                                       input logic [4:0] rd);
        return {sf, 2'b00, 8'b1101_0110, 5'd3, 3'b010, 1'b1, sz, 5'd7, rd};
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic next_rand();
        lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
    endtask

    // drive on a falling edge, sample on the next falling edge
    task automatic issue(input logic [31:0] w, input logic [31:0] a,
                         input logic [63:0] d, input logic en);
        op_word = w; src_acc = a; src_data = d; crc_enable = en; op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic run_legal(input logic sf, input logic [1:0] sz,
                             input logic [31:0] a, input logic [63:0] d,
                             input int w, input string req);
        logic [4:0] rd = 5'(d[4:0] ^ a[9:5]);
        logic [31:0] e = ref_crc(a, d, w);
        issue(mk(sf, sz, rd), a, d, 1'b1);
        check(res_valid === 1'b1 && res_undef === 1'b0, "R1", {res_valid, res_undef}, 2'b10);
        check(res_crc === e, req, res_crc, e);
        check(res_dst === rd, "R10", res_dst, rd);
    endtask

    task automatic run_undef(input logic [31:0] w, input logic en, input string req);
        issue(w, lfsr[31:0], lfsr, en);
        check(res_valid === 1'b1 && res_undef === 1'b1 && res_crc === 32'h0, req,
              {res_valid, res_undef, res_crc}, {2'b11, 32'h0});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(res_valid === 1'b0, "R1", res_valid, 1'b0);
        @(negedge clk);

        // R2 exhaustive byte values, varied accumulators
        for (int b = 0; b < 256; b++) begin
            next_rand();
            run_legal(1'b0, 2'b00, (b[0] ? lfsr[63:32] : 32'h0), 64'(b), 8, "R2");
        end
        // R3 R4 R5 random operands
        for (int k = 0; k < 40; k++) begin
            next_rand(); run_legal(1'b0, 2'b01, lfsr[31:0], {lfsr[31:0], lfsr[63:32]}, 16, "R3");
            next_rand(); run_legal(1'b0, 2'b10, lfsr[63:32], lfsr, 32, "R4");
            next_rand(); run_legal(1'b1, 2'b11, lfsr[40:9], lfsr, 64, "R5");
        end
        // R1 valid drops after an idle cycle
        @(negedge clk);
        check(res_valid === 1'b0, "R1", res_valid, 1'b0);

        // R6 upper data bits ignored
        for (int k = 0; k < 16; k++) begin
            logic [31:0] e8, e16;
            next_rand();
            issue(mk(1'b0, 2'b00, 5'd1), 32'h1234ABCD, {lfsr[63:8], 8'h5A}, 1'b1);
            e8 = ref_crc(32'h1234ABCD, 64'h5A, 8);
            check(res_crc === e8, "R6", res_crc, e8);
            issue(mk(1'b0, 2'b01, 5'd2), 32'h0, {lfsr[63:16], 16'hBEEF}, 1'b1);
            e16 = ref_crc(32'h0, 64'hBEEF, 16);
            check(res_crc === e16, "R6", res_crc, e16);
        end

        // R7 illegal width combinations
        for (int sz = 0; sz < 3; sz++) run_undef(mk(1'b1, 2'(sz), 5'd4), 1'b1, "R7");
        run_undef(mk(1'b0, 2'b11, 5'd4), 1'b1, "R7");

        // R8 each fixed bit flipped
        for (int bit_i = 12; bit_i <= 30; bit_i++) begin
            if (bit_i >= 16 && bit_i <= 20) continue;
            run_undef(mk(1'b0, 2'b10, 5'd9) ^ (32'h1 << bit_i), 1'b1, "R8");
        end

        // R9 feature disabled on all legal forms
        for (int sz = 0; sz < 4; sz++) run_undef(mk(sz == 3, 2'(sz), 5'd5), 1'b0, "R9");

        // R11 check string
        begin
            logic [31:0] c = 32'hFFFFFFFF;
            string s = "123456789";
            for (int i = 0; i < 9; i++) begin
                issue(mk(1'b0, 2'b00, 5'd0), c, 64'(s[i]), 1'b1);
                c = res_crc;
            end
            check(~c === 32'hE3069283, "R11", ~c, 32'hE3069283);
        end
        // R11 one word op equals four chained byte ops
        for (int k = 0; k < 8; k++) begin
            logic [31:0] c, a, wres;
            next_rand();
            a = lfsr[63:32];
            issue(mk(1'b0, 2'b10, 5'd0), a, {32'h0, lfsr[31:0]}, 1'b1);
            wres = res_crc;
            c = a;
            for (int j = 0; j < 4; j++) begin
                issue(mk(1'b0, 2'b00, 5'd0), c, 64'(lfsr[8*j +: 8]), 1'b1);
                c = res_crc;
            end
            check(c === wres, "R11", c, wres);
        end

        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule